// File: doc/BRIEF.md
# Paged DMA Address Translation Unit

This block turns a window-relative DMA address from a device into a physical page address. It holds an on-chip table of translation entries, one entry for each I/O page. The page size is a power of two chosen by a page-shift setting. Bits 1:0 of each entry carry an access permission, and the bits above the page boundary carry the physical page address.

Each accepted lookup returns four things a cycle later: the page-aligned input address, the translated physical page address, the mask of in-page offset bits and the permission code. It also returns a fault flag that compares the requested access type against that permission. Lookups and responses both use a valid/ready handshake.

A maintenance engine uses three controls. It loads entries through a separate write port, zeroes the whole table with a one-cycle clear, and enables or disables the table through a configuration strobe that sets the page shift and the entry count.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset every entry is zero, the page shift is 12 and the entry count is NUM_ENTRIES (16). No response is pending and req_ready is 1. A lookup at any in-range address therefore returns permission 0 with the fault flag set.
- R2: The entry index is req_addr shifted right by the page shift. With page mask PM = ~(2^shift − 1), an in-range lookup (index < entry count) returns rsp_iova = req_addr & PM, rsp_phys = entry & PM, rsp_mask = ~PM and rsp_perm = entry[1:0].
- R3: A lookup whose index is not below the entry count returns rsp_perm 0, rsp_iova 0, rsp_phys 0, rsp_mask all ones and rsp_fault 1.
- R4: Permission codes are 0 none, 1 read-only, 2 write-only and 3 read-write. req_wr = 0 asks for a read, which needs bit 0 of the code. req_wr = 1 asks for a write, which needs bit 1. rsp_fault is 1 whenever the requested access is not allowed.
- R5: A lookup is accepted when req_valid and req_ready are both 1. Its response appears on rsp_valid at the next clock edge. req_ready equals !rsp_valid || rsp_ready. While rsp_valid is 1 and rsp_ready is 0, every response field holds its value.
- R6: A write on the entry port (tbl_wr_en) updates the entry at the next edge. A lookup accepted in the same cycle as the write sees the old entry value.
- R7: tbl_clr zeroes every entry at the next edge and takes priority over a write in the same cycle.
- R8: cfg_load with cfg_enable = 1 only acts while the entry count is 0. It then sets the page shift to cfg_shift and the count to cfg_count, clamped to NUM_ENTRIES. A count of 0 leaves the table disabled. While the count is non-zero, the load is ignored.
- R9: cfg_load with cfg_enable = 0 sets both the entry count and the page shift to 0, so every lookup returns the R3 response.
- R10: A configuration change takes effect only for lookups accepted after the edge that applies it. A lookup accepted in the same cycle uses the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration strobe |
| cfg_enable | input | 1 | 1 enables the table, 0 disables it |
| cfg_shift | input | SHIFT_W (5) | Page shift applied on enable |
| cfg_count | input | CNT_W (5) | Entry count applied on enable |
| tbl_clr | input | 1 | Zero all entries |
| tbl_wr_en | input | 1 | Entry write strobe |
| tbl_wr_idx | input | IDX_W (4) | Entry index to write |
| tbl_wr_data | input | ADDR_W (32) | Entry value |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_addr | input | ADDR_W (32) | Window-relative DMA address |
| req_wr | input | 1 | Access type, 1 = write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_iova | output | ADDR_W (32) | Page-aligned input address |
| rsp_phys | output | ADDR_W (32) | Translated physical page address |
| rsp_mask | output | ADDR_W (32) | In-page offset mask |
| rsp_perm | output | 2 | Permission code |
| rsp_fault | output | 1 | Requested access not allowed |

## Verification
The bench targets the index boundary: the last in-range entry and the first index past the count. A design with an off-by-one compare would translate through a stale entry or fault a valid page. Every permission code is tried with both reads and writes, so swapped permission bits show up as faults on allowed accesses.

Writes, clears and configuration changes are each issued in the same cycle as a lookup. A design that forwards new state would return the new entry or settings a cycle early, and a design that lets a write win over a clear would leave a stale entry.

Two configuration cases are also covered. A re-enable while already enabled must change nothing, or the page size would silently move. An oversized count must clamp, or the table would read past its last entry. A stalled response must hold steady, or a later lookup would overwrite it.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RO   = 2'd1,
    PERM_WO   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  // read needs bit 0, write needs bit 1
  function automatic logic perm_allows(input logic [1:0] perm, input logic is_write);
    return is_write ? perm[1] : perm[0];
  endfunction

endpackage

// File: rtl/dxu_cfg.sv
module dxu_cfg #(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  parameter int DEF_SHIFT   = 12,
  localparam int SHIFT_W    = $clog2(ADDR_W),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               enable,
  input  logic [SHIFT_W-1:0] shift_in,
  input  logic [CNT_W-1:0]   count_in,
  output logic [SHIFT_W-1:0] shift_q,
  output logic [CNT_W-1:0]   count_q
);

  localparam logic [CNT_W-1:0]   MAX_CNT   = CNT_W'(NUM_ENTRIES);
  localparam logic [SHIFT_W-1:0] RST_SHIFT = SHIFT_W'(DEF_SHIFT);

  logic [SHIFT_W-1:0] shift_d;
  logic [CNT_W-1:0]   count_d;
  logic               cfg_en;

  always_comb begin
    shift_d = shift_q;
    count_d = count_q;
    cfg_en  = 1'b0;
    if (load) begin
      if (!enable) begin
        cfg_en  = 1'b1;
        shift_d = '0;
        count_d = '0;
      end else if (count_q == '0) begin
        cfg_en = 1'b1;
        if (count_in == '0) begin
          shift_d = '0;
          count_d = '0;
        end else begin
          shift_d = shift_in;
          count_d = (count_in > MAX_CNT) ? MAX_CNT : count_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= RST_SHIFT;
      count_q <= MAX_CNT;
    end else if (cfg_en) begin
      shift_q <= shift_d;
      count_q <= count_d;
    end
  end

  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= MAX_CNT);

  assert_disabled_zero_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == '0) |-> (shift_q == '0));

  assert_reenable_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && enable && count_q != '0) |=> ($stable(shift_q) && $stable(count_q)));

endmodule

// File: rtl/dxu_table.sv
module dxu_table #(
  parameter int NUM_ENTRIES = 16,
  parameter int DATA_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent_view [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic [DATA_W-1:0] ent_d;
    logic              ent_en;

    always_comb begin
      ent_en = clr || (wr_en && (wr_idx == IDX_W'(g)));
      ent_d  = clr ? '0 : wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ent_view[g] = ent_q;
  end

  assign rd_data = ent_view[rd_idx];

  assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_data == '0));

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (ent_view[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/dxu_lookup.sv
module dxu_lookup
  import dxu_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int ADDR_W      = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SHIFT_W    = $clog2(ADDR_W),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_wr,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [CNT_W-1:0]   count,
  output logic [IDX_W-1:0]   rd_idx,
  input  logic [ADDR_W-1:0]  ent_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_phys,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_fault
);

  logic [ADDR_W-1:0] idx_full, page_mask;
  logic              in_range, accept, valid_d;
  logic [ADDR_W-1:0] iova_d, phys_d, mask_d;
  logic [1:0]        perm_d;
  logic              fault_d;

  always_comb begin
    idx_full  = req_addr >> shift;
    in_range  = idx_full < ADDR_W'(count);
    rd_idx    = idx_full[IDX_W-1:0];
    page_mask = ~((ADDR_W'(1) << shift) - ADDR_W'(1));
    if (in_range) begin
      iova_d = req_addr & page_mask;
      phys_d = ent_data & page_mask;
      mask_d = ~page_mask;
      perm_d = ent_data[1:0];
    end else begin
      iova_d = '0;
      phys_d = '0;
      mask_d = '1;
      perm_d = PERM_NONE;
    end
    fault_d = !perm_allows(perm_d, req_wr);
  end

  always_comb begin
    req_ready = !rsp_valid || rsp_ready;
    accept    = req_valid && req_ready;
    valid_d   = accept ? 1'b1 : (rsp_ready ? 1'b0 : rsp_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_iova  <= '0;
      rsp_phys  <= '0;
      rsp_mask  <= '0;
      rsp_perm  <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_iova  <= iova_d;
      rsp_phys  <= phys_d;
      rsp_mask  <= mask_d;
      rsp_perm  <= perm_d;
      rsp_fault <= fault_d;
    end
  end

  assert_no_perm_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perm == PERM_NONE) |-> rsp_fault);

  assert_aligned_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (((rsp_phys & rsp_mask) == '0) && ((rsp_iova & rsp_mask) == '0)));

  assert_outside_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mask == '1) |-> (rsp_perm == PERM_NONE && rsp_phys == '0 && rsp_iova == '0 && rsp_fault));

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_phys) && $stable(rsp_iova) && $stable(rsp_perm)));

  assert_valid_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit #(
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int DEF_SHIFT   = 12,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int SHIFT_W    = $clog2(ADDR_W),
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic               cfg_enable,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic [CNT_W-1:0]   cfg_count,
  input  logic               tbl_clr,
  input  logic               tbl_wr_en,
  input  logic [IDX_W-1:0]   tbl_wr_idx,
  input  logic [ADDR_W-1:0]  tbl_wr_data,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_wr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_iova,
  output logic [ADDR_W-1:0]  rsp_phys,
  output logic [ADDR_W-1:0]  rsp_mask,
  output logic [1:0]         rsp_perm,
  output logic               rsp_fault
);

  logic [SHIFT_W-1:0] cur_shift;
  logic [CNT_W-1:0]   cur_count;
  logic [IDX_W-1:0]   lk_idx;
  logic [ADDR_W-1:0]  lk_entry;

  dxu_cfg #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W),
    .DEF_SHIFT   (DEF_SHIFT)
  ) i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .enable   (cfg_enable),
    .shift_in (cfg_shift),
    .count_in (cfg_count),
    .shift_q  (cur_shift),
    .count_q  (cur_count)
  );

  dxu_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .DATA_W      (ADDR_W)
  ) i_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tbl_clr),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_data (tbl_wr_data),
    .rd_idx  (lk_idx),
    .rd_data (lk_entry)
  );

  dxu_lookup #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W)
  ) i_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .shift     (cur_shift),
    .count     (cur_count),
    .rd_idx    (lk_idx),
    .ent_data  (lk_entry),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_iova  (rsp_iova),
    .rsp_phys  (rsp_phys),
    .rsp_mask  (rsp_mask),
    .rsp_perm  (rsp_perm),
    .rsp_fault (rsp_fault)
  );

endmodule

// File: tb/test_dma_xlate_unit.sv
module test_dma_xlate_unit;

  localparam int AW = 32;
  localparam int NE = 16;
  localparam int IW = 4;
  localparam int SW = 5;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_load, cfg_enable;
  logic [SW-1:0] cfg_shift;
  logic [CW-1:0] cfg_count;
  logic          tbl_clr, tbl_wr_en;
  logic [IW-1:0] tbl_wr_idx;
  logic [AW-1:0] tbl_wr_data;
  logic          req_valid, req_ready, req_wr;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_ready, rsp_fault;
  logic [AW-1:0] rsp_iova, rsp_phys, rsp_mask;
  logic [1:0]    rsp_perm;

  always #2 clk = ~clk;

  dma_xlate_unit i_dma_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(cfg_load), .cfg_enable(cfg_enable), .cfg_shift(cfg_shift), .cfg_count(cfg_count),
    .tbl_clr(tbl_clr), .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_wr(req_wr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_iova(rsp_iova), .rsp_phys(rsp_phys),
    .rsp_mask(rsp_mask), .rsp_perm(rsp_perm), .rsp_fault(rsp_fault)
  );

  int n_chk  = 0;
  int n_fail = 0;
  logic [AW-1:0] mdl [NE];

  // vector fields: addr[36:5] wr[4] perm[3:2] fault[1] in_range[0]
  localparam int NV = 12;
  localparam logic [36:0] VEC [NV] = '{
    {32'h0000_0123, 1'b0, 2'd0, 1'b1, 1'b1},
    {32'h0000_1FFF, 1'b0, 2'd1, 1'b0, 1'b1},
    {32'h0000_1004, 1'b1, 2'd1, 1'b1, 1'b1},
    {32'h0000_2010, 1'b0, 2'd2, 1'b1, 1'b1},
    {32'h0000_2FF0, 1'b1, 2'd2, 1'b0, 1'b1},
    {32'h0000_3ABC, 1'b0, 2'd3, 1'b0, 1'b1},
    {32'h0000_3ABC, 1'b1, 2'd3, 1'b0, 1'b1},
    {32'h0000_4000, 1'b1, 2'd0, 1'b1, 1'b1},
    {32'h0000_F777, 1'b0, 2'd3, 1'b0, 1'b1},
    {32'h0000_E001, 1'b1, 2'd2, 1'b0, 1'b1},
    {32'h0001_0000, 1'b0, 2'd0, 1'b1, 1'b0},
    {32'h8000_0000, 1'b1, 2'd0, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] addr, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_wr = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [AW-1:0] addr, input int shift,
                            input bit inr, input logic [1:0] perm, input logic fault);
    logic [AW-1:0] pm, e_iova, e_phys, e_mask, ent;
    pm  = ~((32'd1 << shift) - 32'd1);
    ent = inr ? mdl[(addr >> shift) % NE] : '0;
    e_iova = inr ? (addr & pm) : '0;
    e_phys = inr ? (ent & pm) : '0;
    e_mask = inr ? ~pm : '1;
    chk({req, " valid"}, AW'(rsp_valid), 32'd1);
    chk({req, " iova"},  rsp_iova, e_iova);
    chk({req, " phys"},  rsp_phys, e_phys);
    chk({req, " mask"},  rsp_mask, e_mask);
    chk({req, " perm"},  AW'(rsp_perm), AW'(perm));
    chk({req, " fault"}, AW'(rsp_fault), AW'(fault));
  endtask

  task automatic lookup(input string req, input logic [AW-1:0] addr, input logic wr, input int shift,
                        input bit inr, input logic [1:0] perm, input logic fault);
    send(addr, wr);
    expect_rsp(req, addr, shift, inr, perm, fault);
  endtask

  task automatic write_ent(input int idx, input logic [AW-1:0] val);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_idx = IW'(idx); tbl_wr_data = val;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic cfg(input logic en, input int shift, input int count);
    @(negedge clk);
    cfg_load = 1'b1; cfg_enable = en; cfg_shift = SW'(shift); cfg_count = CW'(count);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_load = 0; cfg_enable = 0; cfg_shift = 0; cfg_count = 0;
    tbl_clr = 0; tbl_wr_en = 0; tbl_wr_idx = 0; tbl_wr_data = 0;
    req_valid = 0; req_addr = 0; req_wr = 0; rsp_ready = 1;
    for (int i = 0; i < NE; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rsp_valid", AW'(rsp_valid), 32'd0);
    chk("R1 req_ready", AW'(req_ready), 32'd1);
    lookup("R1 zero entry", 32'h0000_3123, 1'b0, 12, 1, 2'd0, 1'b1);

    // R6 program entries; perm = idx & 3
    for (int i = 0; i < NE; i++)
      write_ent(i, 32'h8000_0A5C | (i << 20) | (i & 3));

    // R2 R3 R4 vector walk
    for (int v = 0; v < NV; v++) begin
      lookup($sformatf("R2/R3/R4 vec%0d", v), VEC[v][36:5], VEC[v][4], 12,
             VEC[v][0], VEC[v][3:2], VEC[v][1]);
    end

    // R6 write and lookup in the same cycle: old value returned
    @(negedge clk);
    tbl_wr_en = 1; tbl_wr_idx = 4'd5; tbl_wr_data = 32'h0000_7002;
    req_valid = 1; req_addr = 32'h0000_5000; req_wr = 0;
    @(negedge clk);
    tbl_wr_en = 0; req_valid = 0;
    expect_rsp("R6 old value", 32'h0000_5000, 12, 1, 2'd1, 1'b0);
    mdl[5] = 32'h0000_7002;
    lookup("R6 new value", 32'h0000_5000, 1'b0, 12, 1, 2'd2, 1'b1);

    // R5 backpressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_addr = 32'h0000_3ABC; req_wr = 0;
    @(negedge clk);
    req_addr = 32'h0000_1000;
    chk("R5 ready low on stall", AW'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R5 held iova", rsp_iova, 32'h0000_3000);
    chk("R5 held valid", AW'(rsp_valid), 32'd1);
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_rsp("R5 next after release", 32'h0000_1000, 12, 1, 2'd1, 1'b0);

    // R7 clear wins over write
    @(negedge clk);
    tbl_clr = 1; tbl_wr_en = 1; tbl_wr_idx = 4'd2; tbl_wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    tbl_clr = 0; tbl_wr_en = 0;
    for (int i = 0; i < NE; i++) mdl[i] = '0;
    lookup("R7 cleared idx2", 32'h0000_2000, 1'b1, 12, 1, 2'd0, 1'b1);
    lookup("R7 cleared idx9", 32'h0000_9000, 1'b0, 12, 1, 2'd0, 1'b1);

    // R10 disable in the same cycle as a lookup
    write_ent(7, 32'h4444_4003);
    @(negedge clk);
    cfg_load = 1; cfg_enable = 0; cfg_shift = 0; cfg_count = 0;
    req_valid = 1; req_addr = 32'h0000_7010; req_wr = 0;
    @(negedge clk);
    cfg_load = 0; req_valid = 0;
    expect_rsp("R10 old config used", 32'h0000_7010, 12, 1, 2'd3, 1'b0);

    // R9 disabled table faults everything
    lookup("R9 disabled", 32'h0000_7010, 1'b0, 0, 0, 2'd0, 1'b1);
    lookup("R9 disabled addr0", 32'h0000_0000, 1'b1, 0, 0, 2'd0, 1'b1);

    // R8 enable with 64 KiB pages, four entries
    cfg(1'b1, 16, 4);
    write_ent(1, 32'h1234_5673);
    lookup("R8 shift16 hit", 32'h0001_ABCD, 1'b1, 16, 1, 2'd3, 1'b0);
    lookup("R8 beyond count", 32'h0004_0000, 1'b0, 16, 0, 2'd0, 1'b1);
    cfg(1'b1, 12, 8);
    lookup("R8 reenable ignored", 32'h0002_0000, 1'b0, 16, 1, 2'd0, 1'b1);

    // R8 clamp of oversized count
    cfg(1'b0, 0, 0);
    cfg(1'b1, 12, 31);
    lookup("R8 clamp last entry", 32'h0000_F000, 1'b0, 12, 1, 2'd0, 1'b1);
    lookup("R8 clamp past end", 32'h0001_0000, 1'b0, 12, 0, 2'd0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule